// File: doc/BRIEF.md
# Presettable Binary Counter with Terminal-Count Reload

This block is a synchronous up-counter of parameter width (eight bits by default). It can be preset from a parallel bus, and it raises an active-low flag whenever every count bit is one. An active-low load input copies the preset bus into the counter. An active-low enable input picks between counting and holding.

A gated feedback input, `reload`, sets what happens at the top of the range. When it is low, the counter wraps to zero and runs freely. When it is high, the edge that would wrap loads the preset value instead. The block then divides the clock by 2^W minus the preset, with no gating outside the block. For example, a preset of 0x8F gives a divide ratio of 113.

A registered, active-high divide output marks each cycle that follows a terminal state. Only the flag `term_n` is meant for chaining several counters, where it feeds the next stage's enable. An asynchronous clear overrides every other function.

Each edge performs exactly one operation. A decoder picks it from five named operations:

- OP_LOAD: explicit preset.
- OP_INC: increment.
- OP_WRAP: roll from all-ones to zero.
- OP_RELOAD: preset taken at the terminal state.
- OP_HOLD: keep the value.

The decoder chooses again on every edge from the current inputs and the terminal condition. Any operation can follow any other, and there is no other sequencing state.

Top module: `preset_reload_counter`

## Requirements
- R1: Raising `clear` at any time, with or without a clock edge, forces `count` to zero, `term_n` to 1 and `div_pulse` to 0. While `clear` stays high, clock edges change nothing, whatever the other inputs are.
- R2: On a rising edge with `load_n` low, `count` takes the value of `preset`, whatever `cnt_en_n` and `reload` are.
- R3: On a rising edge with `load_n` high, `cnt_en_n` low and `count` not all-ones, `count` increases by one.
- R4: On a rising edge with `load_n` high and `cnt_en_n` high, `count` keeps its value. This includes the all-ones state with `reload` high.
- R5: `term_n` is 0 exactly while every bit of `count` is 1, and 1 otherwise.
- R6: With `reload` low, `load_n` high and `cnt_en_n` low, the edge taken at all-ones sets `count` to zero.
- R7: With `reload` high, `load_n` high and `cnt_en_n` low, the edge taken at all-ones loads `preset`. Held in this mode, the counter marks a terminal state once every 2^W − `preset` cycles, so a preset of 0x8F gives period 113 and a preset of 0xFE gives period 2.
- R8: After each rising edge, `div_pulse` is 1 exactly when `count` was all-ones just before that edge.
- R9: When an explicit load meets the terminal state in the same cycle, the explicit load decides. `count` takes `preset`, and `div_pulse` still marks the terminal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Asynchronous clear, active high |
| load_n | input | 1 | Parallel load, active low |
| cnt_en_n | input | 1 | Count enable, active low; high holds |
| reload | input | 1 | Enables preset reload at the terminal state |
| preset | input | W | Parallel preset value |
| count | output | W | Counter value |
| term_n | output | 1 | Terminal flag, low when count is all-ones |
| div_pulse | output | 1 | Registered terminal marker, active high |

## Verification
Two functions can collide in the same cycle: an explicit load, and the terminal-state handling (either wrap or reload). The bench provokes this by driving `load_n` low while the counter sits at all-ones with `reload` high and counting enabled. It expects the explicit preset rather than the reload value, and it expects `div_pulse` to mark the terminal cycle on the next edge anyway.

A second collision is between the asynchronous clear and the edge-driven functions. The bench raises `clear` between edges and checks the outputs at once. It then keeps the clock running with a load requested and confirms that the count stays at zero.

// File: rtl/prc_pkg.sv
`timescale 1ns/1ps
package prc_pkg;
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_INC    = 3'd1,
        OP_WRAP   = 3'd2,
        OP_RELOAD = 3'd3,
        OP_LOAD   = 3'd4
    } op_e;
endpackage

// File: rtl/prc_mode_dec.sv
`timescale 1ns/1ps
module prc_mode_dec
    import prc_pkg::*;
(
    input  logic load_n,
    input  logic cnt_en_n,
    input  logic reload,
    input  logic at_top,
    output op_e  op
);
    // Explicit load outranks hold, which outranks the terminal handling.
    always_comb begin
        unique casez ({load_n, cnt_en_n, reload, at_top})
            4'b0???: op = OP_LOAD;
            4'b11??: op = OP_HOLD;
            4'b10?0: op = OP_INC;
            4'b1001: op = OP_WRAP;
            4'b1011: op = OP_RELOAD;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/prc_state_reg.sv
`timescale 1ns/1ps
module prc_state_reg
    import prc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clear,
    input  op_e          op,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_nxt;

    always_comb begin
        unique case (op)
            OP_LOAD,
            OP_RELOAD: count_nxt = preset;
            OP_INC:    count_nxt = count + ONE;
            OP_WRAP:   count_nxt = '0;
            OP_HOLD:   count_nxt = count;
            default:   count_nxt = count;
        endcase
    end

    always_ff @(posedge clk or posedge clear) begin
        if (clear) count <= '0;
        else       count <= count_nxt;
    end
endmodule

// File: rtl/prc_term_gen.sv
`timescale 1ns/1ps
module prc_term_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clear,
    input  logic [W-1:0] count,
    output logic         at_top,
    output logic         term_n,
    output logic         div_pulse
);
    assign at_top = &count;
    assign term_n = ~at_top;

    always_ff @(posedge clk or posedge clear) begin
        if (clear) div_pulse <= 1'b0;
        else       div_pulse <= at_top;
    end
endmodule

// File: rtl/preset_reload_counter.sv
`timescale 1ns/1ps
module preset_reload_counter
    import prc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load_n,
    input  logic         cnt_en_n,
    input  logic         reload,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         term_n,
    output logic         div_pulse
);
    op_e  op;
    logic at_top;

    prc_mode_dec u_dec (
        .load_n   (load_n),
        .cnt_en_n (cnt_en_n),
        .reload   (reload),
        .at_top   (at_top),
        .op       (op)
    );

    prc_state_reg #(.W(W)) u_state (
        .clk    (clk),
        .clear  (clear),
        .op     (op),
        .preset (preset),
        .count  (count)
    );

    prc_term_gen #(.W(W)) u_term (
        .clk       (clk),
        .clear     (clear),
        .count     (count),
        .at_top    (at_top),
        .term_n    (term_n),
        .div_pulse (div_pulse)
    );
endmodule

// File: rtl/preset_reload_counter_chk.sv
`timescale 1ns/1ps
module preset_reload_counter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clear,
    input logic         load_n,
    input logic         cnt_en_n,
    input logic         reload,
    input logic [W-1:0] preset,
    input logic [W-1:0] count,
    input logic         term_n,
    input logic         div_pulse
);
    // R1: clear dominates at every sampled edge
    p_clear_r1: assert property (@(posedge clk)
        clear |-> (count == '0 && term_n && !div_pulse));

    // R2 and R9: an explicit load always wins
    p_load_r2: assert property (@(posedge clk) disable iff (clear)
        !load_n |=> count == $past(preset));

    p_inc_r3: assert property (@(posedge clk) disable iff (clear)
        (load_n && !cnt_en_n && term_n) |=> count == W'($past(count) + W'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (clear)
        (load_n && cnt_en_n) |=> $stable(count));

    p_wrap_r6: assert property (@(posedge clk) disable iff (clear)
        (load_n && !cnt_en_n && !reload && !term_n) |=> count == '0);

    p_reload_r7: assert property (@(posedge clk) disable iff (clear)
        (load_n && !cnt_en_n && reload && !term_n) |=> count == $past(preset));

    p_div_r8: assert property (@(posedge clk) disable iff (clear)
        1'b1 |=> div_pulse == !$past(term_n));
endmodule

bind preset_reload_counter preset_reload_counter_chk #(.W(W)) u_chk (
    .clk       (clk),
    .clear     (clear),
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .reload    (reload),
    .preset    (preset),
    .count     (count),
    .term_n    (term_n),
    .div_pulse (div_pulse)
);

// File: tb/tb_preset_reload_counter.sv
`timescale 1ns/1ps
module tb_preset_reload_counter;
    localparam int W = 8;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         clear = 1'b1;
    logic         load_n = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         reload = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         term_n;
    logic         div_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    preset_reload_counter #(.W(W)) dut (
        .clk(clk), .clear(clear), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .reload(reload), .preset(preset), .count(count),
        .term_n(term_n), .div_pulse(div_pulse)
    );

    // Fields: load_n, cnt_en_n, reload, preset, expected count, term_n, div_pulse.
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 8'hFD, 8'hFD, 1'b1, 1'b0},  // R2 load ignores hold/reload
        {1'b1, 1'b0, 1'b0, 8'h00, 8'hFE, 1'b1, 1'b0},  // R3
        {1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0},  // R5 terminal reached
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},  // R6 wrap, R8 marker
        {1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},  // R4 hold
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R2
        {1'b1, 1'b1, 1'b1, 8'h80, 8'hFF, 1'b0, 1'b1},  // R4 hold at top with reload
        {1'b1, 1'b0, 1'b1, 8'h80, 8'h80, 1'b1, 1'b1},  // R7 reload
        {1'b1, 1'b0, 1'b1, 8'h80, 8'h81, 1'b1, 1'b0},  // R3
        {1'b0, 1'b0, 1'b1, 8'hFE, 8'hFE, 1'b1, 1'b0},  // R2
        {1'b1, 1'b0, 1'b1, 8'h10, 8'hFF, 1'b0, 1'b0},  // R3, R5
        {1'b0, 1'b0, 1'b1, 8'h33, 8'h33, 1'b1, 1'b1}   // R9 load beats reload
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic ld, input logic ce, input logic rl, input logic [W-1:0] pv);
        @(negedge clk);
        load_n = ld; cnt_en_n = ce; reload = rl; preset = pv;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int last;
        int gap;
        #7;
        chk(count == 0 && term_n && !div_pulse, "R1 reset state", count, 0);
        @(negedge clk);
        clear = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:10]);
            chk(count == VEC[i][9:2], "R2/R3/R4/R6/R7/R9 count", count, VEC[i][9:2]);
            chk(term_n == VEC[i][1], "R5 term_n", term_n, VEC[i][1]);
            chk(div_pulse == VEC[i][0], "R8 div_pulse", div_pulse, VEC[i][0]);
        end

        // R7: divide by 113 using preset 0x8F
        step(1'b0, 1'b0, 1'b1, 8'h8F);
        load_n = 1'b1;
        last = -1;
        for (int c = 0; c < 400; c++) begin
            @(posedge clk); #1;
            if (div_pulse) begin
                if (last >= 0) begin
                    gap = c - last;
                    chk(gap == 113, "R7 divide-by-113 period", gap, 113);
                end
                last = c;
            end
        end

        // R7: divide by 2 using preset 0xFE
        step(1'b0, 1'b0, 1'b1, 8'hFE);
        load_n = 1'b1;
        last = -1;
        for (int c = 0; c < 8; c++) begin
            @(posedge clk); #1;
            if (div_pulse) begin
                if (last >= 0) begin
                    gap = c - last;
                    chk(gap == 2, "R7 divide-by-2 period", gap, 2);
                end
                last = c;
            end
        end

        // R1: asynchronous clear between edges, then held against a load
        step(1'b0, 1'b0, 1'b0, 8'hFF);
        chk(count == 8'hFF && !term_n, "R5 all-ones before clear", count, 8'hFF);
        #0.5;
        clear = 1'b1;
        #0.2;
        chk(count == 0, "R1 async clear count", count, 0);
        chk(term_n == 1'b1, "R1 async clear term_n", term_n, 1);
        preset = 8'h5A;
        load_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(count == 0 && !div_pulse, "R1 clear outranks load", count, 0);
        @(negedge clk);
        clear = 1'b0;
        step(1'b0, 1'b1, 1'b0, 8'h5A);
        chk(count == 8'h5A, "R2 load after clear", count, 8'h5A);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule